// File: doc/BRIEF.md
# Supervisor Address Translation Control Register

This block keeps the supervisor register that selects the address-translation scheme of a hart. It stores three fields: a translation mode, an address-space identifier (ASID) and the physical page number of the root page table. One parameter selects a 32-bit or a 64-bit hart, and that choice sets where each field sits and which modes exist. A write is first checked against the table of modes the hart supports. A write whose mode is not in the table is dropped without any response.

The block also enforces the trap-virtual-memory control. When that bit is set and the hart runs in supervisor mode, any read is refused and any write that would take effect is refused. The block raises an illegal-access flag in the same cycle so that the pipeline can take an exception. The block also decides when cached translations are stale. An accepted write that changes the ASID produces a one-cycle flush request. A write to the status register that changes one of the fields that affect translation also produces a flush request. If the hart has no MMU, the register reads as zero and ignores all writes.

Top module: `satp_ctrl`

## Requirements
- R1: After reset the register holds all zeros (Bare mode), `rd_data` is zero and `tlb_flush` is low.
- R2: While `mmu_present` is low, `rd_data` is zero, `illegal` stays low, and writes leave the stored value unchanged.
- R3: On a 64-bit hart the mode field is `wr_data[63:60]`. Only the codes 0 (Bare), 8 (Sv39), 9 (Sv48) and 10 (Sv57) are accepted. A write with any other code is discarded: the value is unchanged, there is no flush and there is no illegal flag.
- R4: On a 32-bit hart the mode field is `wr_data[31]`, and both codes are accepted: 0 (Bare) and 1 (Sv32).
- R5: A write takes effect only if its word differs from the stored value. A write of the stored value changes nothing, raises no flush and raises no illegal flag, even under the trap control.
- R6: When `priv` is 1 (supervisor; 0 is user, 3 is machine), `tvm` is high and an MMU is present, the following apply. A read (`rd_en`) raises `illegal` in the same cycle. A write that passes R3/R5 also raises `illegal` in the same cycle. `rd_data` reads zero, and the stored value is unchanged.
- R7: An accepted write that changes the ASID field (`[59:44]` on 64-bit, `[30:22]` on 32-bit) raises `tlb_flush` for the single cycle after the write's clock edge. An accepted write that changes only the mode or the page number does not raise it.
- R8: The status bit vector is laid out as `[0]` SUM, `[1]` MXR, `[2]` MPRV, `[4:3]` MPP and `[5]` MPV. When `stat_wr_en` is high and `stat_cur` differs from `stat_nxt` in bits [4:0], `tlb_flush` rises in the following cycle.
- R9: A difference in the MPV bit alone triggers a flush on a 64-bit hart and has no effect on a 32-bit hart.
- R10: `tlb_flush` is registered. It never follows a discarded, identical or trapped write unless a status change also calls for a flush.
- R11: In any other case `rd_data` shows the value stored by the most recent accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | XLEN | Word to write |
| rd_en | input | 1 | Read request for this cycle |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| tvm | input | 1 | Trap-virtual-memory control bit |
| mmu_present | input | 1 | High when the hart has an MMU |
| stat_wr_en | input | 1 | A status-register write happens this cycle |
| stat_cur | input | 6 | Translation-related status bits before that write |
| stat_nxt | input | 6 | Translation-related status bits after that write |
| rd_data | output | XLEN | Readable register value |
| illegal | output | 1 | The access in this cycle must trap |
| tlb_flush | output | 1 | One-cycle translation-flush request |

## Verification
The bench builds two copies side by side, one with XLEN=64 and one with XLEN=32, and drives both with the same stimulus. The 64-bit copy exercises the four-bit mode field, the rejection of unsupported mode codes and the MPV-triggered flush. The 32-bit copy exercises the single-bit mode field where every code is legal, the narrower ASID position, and the exclusion of MPV from flush detection. Random writes are biased toward exact copies of the stored value and toward page-number-only changes, so that the identical-write and ASID-unchanged cases are hit often.

// File: rtl/satp_ctrl_pkg.sv
package satp_ctrl_pkg;

   typedef enum logic [1:0] {
      PRIV_U   = 2'd0,
      PRIV_S   = 2'd1,
      PRIV_RSV = 2'd2,
      PRIV_M   = 2'd3
   } priv_e;

   // Translation-related status bits, MSB first
   typedef struct packed {
      logic       mpv;
      logic [1:0] mpp;
      logic       mprv;
      logic       mxr;
      logic       sum;
   } xlat_stat_t;

   localparam int STAT_W = $bits(xlat_stat_t);

   // Mode codes of the wide (64-bit) layout
   localparam logic [3:0] MODE_BARE = 4'd0;
   localparam logic [3:0] MODE_SV39 = 4'd8;
   localparam logic [3:0] MODE_SV48 = 4'd9;
   localparam logic [3:0] MODE_SV57 = 4'd10;

   function automatic int mode_width(int xlen);
      return (xlen == 64) ? 4 : 1;
   endfunction

   function automatic int asid_width(int xlen);
      return (xlen == 64) ? 16 : 9;
   endfunction

endpackage

// File: rtl/satp_mode_filter.sv
module satp_mode_filter
   import satp_ctrl_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int MODE_W = mode_width(XLEN)
) (
   input  logic [MODE_W-1:0] mode,
   output logic              ok
);

   generate
      if (XLEN == 64) begin : g_wide
         assign ok = (mode == MODE_BARE) || (mode == MODE_SV39) ||
                     (mode == MODE_SV48) || (mode == MODE_SV57);
      end else if (XLEN == 32) begin : g_narrow
         // single-bit mode: Bare (0) and Sv32 (1) both legal
         assign ok = (mode == 1'b0) || (mode == 1'b1);
      end else begin : g_bad
         $error("satp_mode_filter: XLEN must be 32 or 64");
         assign ok = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/satp_write_gate.sv
module satp_write_gate #(
   parameter int XLEN    = 64,
   parameter int ASID_W  = 16,
   parameter int ASID_LO = 44
) (
   input  logic            wr_en,
   input  logic [XLEN-1:0] wr_data,
   input  logic [XLEN-1:0] cur,
   input  logic            mode_ok,
   input  logic            mmu_present,
   input  logic            trap,
   output logic            accept,
   output logic            commit,
   output logic            asid_chg
);

   logic word_differs;
   logic asid_differs;

   assign word_differs = (wr_data != cur);
   assign asid_differs = (wr_data[ASID_LO +: ASID_W] != cur[ASID_LO +: ASID_W]);

   // a write that would land, before the trap control is applied
   assign accept   = wr_en && mmu_present && mode_ok && word_differs;
   assign commit   = accept && !trap;
   assign asid_chg = commit && asid_differs;

endmodule

// File: rtl/satp_flush_gen.sv
module satp_flush_gen
   import satp_ctrl_pkg::*;
#(
   parameter bit TRACK_MPV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              asid_chg,
   input  logic              stat_wr_en,
   input  logic [STAT_W-1:0] stat_cur,
   input  logic [STAT_W-1:0] stat_nxt,
   output logic              flush
);

   localparam logic [STAT_W-1:0] WATCH = TRACK_MPV ? {STAT_W{1'b1}}
                                                   : {1'b0, {(STAT_W-1){1'b1}}};

   logic stat_hit;

   assign stat_hit = stat_wr_en && (|((stat_cur ^ stat_nxt) & WATCH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush <= 1'b0;
      end else begin
         flush <= asid_chg || stat_hit;
      end
   end

endmodule

// File: rtl/satp_ctrl.sv
module satp_ctrl
   import satp_ctrl_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [XLEN-1:0] wr_data,
   input  logic            rd_en,
   input  logic [1:0]      priv,
   input  logic            tvm,
   input  logic            mmu_present,
   input  logic            stat_wr_en,
   input  logic [5:0]      stat_cur,
   input  logic [5:0]      stat_nxt,
   output logic [XLEN-1:0] rd_data,
   output logic            illegal,
   output logic            tlb_flush
);

   localparam int MODE_W  = mode_width(XLEN);
   localparam int ASID_W  = asid_width(XLEN);
   localparam int PPN_W   = XLEN - MODE_W - ASID_W;
   localparam int ASID_LO = PPN_W;

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_chk_xlen
         $error("satp_ctrl: XLEN must be 32 or 64");
      end
      if (STAT_W != 6) begin : g_chk_stat
         $error("satp_ctrl: status vector width mismatch");
      end
   endgenerate

   logic [XLEN-1:0] satp_q;
   logic            mode_ok;
   logic            trap;
   logic            accept;
   logic            commit;
   logic            asid_chg;

   assign trap = mmu_present && (priv == PRIV_S) && tvm;

   satp_mode_filter #(
      .XLEN   (XLEN),
      .MODE_W (MODE_W)
   ) u_mode (
      .mode (wr_data[XLEN-1 -: MODE_W]),
      .ok   (mode_ok)
   );

   satp_write_gate #(
      .XLEN    (XLEN),
      .ASID_W  (ASID_W),
      .ASID_LO (ASID_LO)
   ) u_gate (
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .cur         (satp_q),
      .mode_ok     (mode_ok),
      .mmu_present (mmu_present),
      .trap        (trap),
      .accept      (accept),
      .commit      (commit),
      .asid_chg    (asid_chg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         satp_q <= '0;
      end else if (commit) begin
         satp_q <= wr_data;
      end
   end

   assign rd_data = (mmu_present && !trap) ? satp_q : '0;
   assign illegal = trap && (rd_en || accept);

   satp_flush_gen #(
      .TRACK_MPV (XLEN == 64)
   ) u_flush (
      .clk        (clk),
      .rst_n      (rst_n),
      .asid_chg   (asid_chg),
      .stat_wr_en (stat_wr_en),
      .stat_cur   (stat_cur),
      .stat_nxt   (stat_nxt),
      .flush      (tlb_flush)
   );

endmodule

// File: rtl/satp_ctrl_chk.sv
module satp_ctrl_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [XLEN-1:0] wr_data,
   input logic            rd_en,
   input logic [1:0]      priv,
   input logic            tvm,
   input logic            mmu_present,
   input logic            stat_wr_en,
   input logic [XLEN-1:0] rd_data,
   input logic            illegal,
   input logic            tlb_flush,
   input logic [XLEN-1:0] cur
);

   // R2: no MMU means zero reads and no trap
   a_r2_nommu_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !mmu_present |-> (rd_data == '0) && !illegal);

   // R2: no MMU means the stored word holds
   a_r2_nommu_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mmu_present |=> $stable(cur));

   // R6: a trapped access leaves the register untouched
   a_r6_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> $stable(cur));

   // R6: the flag appears only for supervisor accesses under the control bit
   a_r6_trap_cond: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (priv == 2'd1) && tvm && mmu_present && (rd_en || wr_en));

   // R5: writing the stored value is never flagged
   a_r5_same_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && (wr_data == cur)) |-> !illegal);

   // R5: with no write the register keeps its value
   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cur));

   // R10: a flush always has a write one cycle earlier
   a_r10_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_flush |-> $past(wr_en || stat_wr_en));

   generate
      if (XLEN == 64) begin : g_wide
         // R3: unsupported mode codes are dropped
         a_r3_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !(wr_data[63:60] inside {4'd0, 4'd8, 4'd9, 4'd10}))
               |=> $stable(cur));
      end
   endgenerate

endmodule

bind satp_ctrl satp_ctrl_chk #(.XLEN(XLEN)) u_satp_ctrl_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_en       (rd_en),
   .priv        (priv),
   .tvm         (tvm),
   .mmu_present (mmu_present),
   .stat_wr_en  (stat_wr_en),
   .rd_data     (rd_data),
   .illegal     (illegal),
   .tlb_flush   (tlb_flush),
   .cur         (satp_q)
);

// File: tb/test_satp_ctrl.sv
`timescale 1ns/1ps
module test_satp_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [1:0]  priv = 2'd3;
   logic        tvm = 1'b0;
   logic        mmu_present = 1'b1;
   logic        stat_wr_en = 1'b0;
   logic [5:0]  stat_cur = '0;
   logic [5:0]  stat_nxt = '0;

   logic [63:0] rd64;
   logic        ill64, fl64;
   logic [31:0] rd32;
   logic        ill32, fl32;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [63:0] m64 = '0;
   logic [31:0] m32 = '0;
   logic        ef64 = 1'b0, ef32 = 1'b0;
   string       tag64 = "R1", tag32 = "R1";

   always #4 clk = ~clk;

   satp_ctrl #(.XLEN(64)) i_satp_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .priv(priv), .tvm(tvm), .mmu_present(mmu_present), .stat_wr_en(stat_wr_en),
      .stat_cur(stat_cur), .stat_nxt(stat_nxt),
      .rd_data(rd64), .illegal(ill64), .tlb_flush(fl64));

   satp_ctrl #(.XLEN(32)) i_satp_ctrl_rv32 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data[31:0]), .rd_en(rd_en),
      .priv(priv), .tvm(tvm), .mmu_present(mmu_present), .stat_wr_en(stat_wr_en),
      .stat_cur(stat_cur), .stat_nxt(stat_nxt),
      .rd_data(rd32), .illegal(ill32), .tlb_flush(fl32));

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit mode_ok64(logic [63:0] d);
      return d[63:60] inside {4'd0, 4'd8, 4'd9, 4'd10};
   endfunction

   // one cycle: drive, check combinational outputs, then check flush of this cycle
   task automatic step(bit w, logic [63:0] d, bit r, logic [1:0] p, bit t, bit mmu,
                       bit sw, logic [5:0] sc, logic [5:0] sn);
      bit trap, acc64, acc32, com64, com32, sh64, sh32, ac64, ac32;
      wr_en = w; wr_data = d; rd_en = r; priv = p; tvm = t; mmu_present = mmu;
      stat_wr_en = sw; stat_cur = sc; stat_nxt = sn;
      #1;
      trap  = mmu && (p == 2'd1) && t;
      acc64 = w && mmu && mode_ok64(d) && (d != m64);
      acc32 = w && mmu && (d[31:0] != m32);
      chk(mmu ? (trap ? "R6 rd64" : "R11 rd64") : "R2 rd64", rd64,
          (mmu && !trap) ? m64 : 64'd0);
      chk(mmu ? (trap ? "R6 rd32" : "R11 rd32") : "R2 rd32", {32'd0, rd32},
          (mmu && !trap) ? {32'd0, m32} : 64'd0);
      chk(w && !mode_ok64(d) ? "R3 ill64" : (w && d == m64 ? "R5 ill64" : "R6 ill64"),
          {63'd0, ill64}, {63'd0, trap && (r || acc64)});
      chk(w && d[31:0] == m32 ? "R5 ill32" : "R6 ill32",
          {63'd0, ill32}, {63'd0, trap && (r || acc32)});
      com64 = acc64 && !trap;
      com32 = acc32 && !trap;
      ac64  = com64 && (d[59:44] != m64[59:44]);
      ac32  = com32 && (d[30:22] != m32[30:22]);
      sh64  = sw && (sc != sn);
      sh32  = sw && (sc[4:0] != sn[4:0]);
      ef64  = ac64 || sh64;
      ef32  = ac32 || sh32;
      tag64 = sh64 ? ((sc[4:0] == sn[4:0]) ? "R9 fl64" : "R8 fl64") : (ac64 ? "R7 fl64" : "R10 fl64");
      tag32 = sh32 ? "R8 fl32" : (sw && sc != sn ? "R9 fl32" : (ac32 ? "R7 fl32" : "R10 fl32"));
      if (com64) m64 = d;
      if (com32) m32 = d[31:0];
      @(negedge clk);
      chk(tag64, {63'd0, fl64}, {63'd0, ef64});
      chk(tag32, {63'd0, fl32}, {63'd0, ef32});
   endtask

   task automatic rd_m();
      step(1'b0, 64'd0, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 6'd0, 6'd0);
   endtask

   task automatic wr_m(logic [63:0] d);
      step(1'b1, d, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 6'd0, 6'd0);
   endtask

   task automatic st(logic [5:0] sc, logic [5:0] sn);
      step(1'b0, 64'd0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, sc, sn);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 rd64", rd64, 64'd0);
      chk("R1 rd32", {32'd0, rd32}, 64'd0);
      chk("R1 fl64", {63'd0, fl64}, 64'd0);
      chk("R1 fl32", {63'd0, fl32}, 64'd0);
      @(negedge clk);

      wr_m(64'h8005_0000_8000_0123);          // R3 Sv39 accepted; R4 Sv32 accepted
      rd_m();                                  // R11
      wr_m(64'h8005_0000_8000_0123);          // R5 identical write
      wr_m(64'h5007_0000_0000_0001);          // R3 mode 5 discarded on wide copy
      wr_m(64'h9005_0000_8000_0456);          // R7 page/mode change only
      wr_m(64'hA00A_0000_C040_0456);          // R7 ASID change, Sv57
      // R6: supervisor under trap control
      step(1'b1, 64'h8001_0000_0000_0777, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 6'd0, 6'd0);
      step(1'b0, 64'd0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 6'd0, 6'd0);
      step(1'b1, 64'hA00A_0000_C040_0456, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 6'd0, 6'd0); // R5
      step(1'b1, 64'h8002_0000_0040_0001, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 6'd0, 6'd0);
      // R2: no MMU
      step(1'b1, 64'h8003_0000_0080_0002, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 6'd0, 6'd0);
      step(1'b0, 64'd0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 6'd0, 6'd0);
      rd_m();
      // R8 and R9: status changes
      st(6'b000000, 6'b100000);               // MPV only
      st(6'b000000, 6'b011000);               // MPP
      st(6'b000010, 6'b000010);               // no change
      st(6'b000001, 6'b000000);               // SUM
      st(6'b100100, 6'b000100);               // MPV only, reversed

      for (int i = 0; i < 600; i++) begin
         logic [63:0] d;
         logic [1:0]  p;
         logic [5:0]  sc;
         int          k;
         k = $urandom % 4;
         case (k)
            0: d = m64 ^ (64'd1 << ($urandom % 20));
            1: begin
               d = {$urandom, $urandom};
               d[63:60] = ($urandom % 5 == 0) ? 4'($urandom) : 4'd8 + 4'($urandom % 3);
               d[31:0] = ($urandom % 3 == 0) ? m32 : d[31:0];
            end
            2: d = {$urandom, $urandom};
            default: d = {m64[63:32], m32};
         endcase
         case ($urandom % 3)
            0: p = 2'd0;
            1: p = 2'd1;
            default: p = 2'd3;
         endcase
         sc = 6'($urandom);
         step(($urandom % 2) == 1, d, ($urandom % 2) == 1, p, ($urandom % 10) < 3,
              ($urandom % 8) != 0, ($urandom % 4) == 0, sc,
              ($urandom % 2) ? sc : 6'($urandom));
      end

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule